// File: doc/BRIEF.md
# Bus transaction trace capture agent

This block listens, without ever stalling it, to the request and response handshakes of one initiator's bus socket. It times each transaction from request acceptance to its reporting response beat and encodes the target from the top address bits against a small table of programmable regions. It then builds a trace record for an off-chip analyzer. Records wait in a small local FIFO and leave through a valid/ready trace stream, either as a single control beat (short format) or as a control beat followed by address beats (full format).

The agent times one transaction at a time. Requests accepted by the bus while a transaction is outstanding go untimed, and so do response beats seen while idle. Configuration arrives through a write-only register port. Address 0 is the control word: bit 0 selects full format, bit 1 reports burst reads on the last data beat instead of the first, bit 2 marks a multi-initiator trace, and bits [9:8] hold this agent's initiator number. Address 1+i programs region i: bits [7:0] are the match value for address bits [31:24], bits [15:8] are the compare mask, and bit 16 enables the region.

The trace stream follows valid/ready rules. Once `trc_vld` is high, it and `trc_data`/`trc_last` hold until `trc_rdy` is seen high at a clock edge. A stalled stream never stalls the observed bus. Records that find no room are dropped, and this is flagged in the next stored record.

Top module: `trc_capture_agent`

## Requirements
- R1: The latency field (head beat bits [7:0]) equals the number of clock edges from the request handshake edge to the reporting response beat edge, so an immediate response gives 1. It saturates at 255.
- R2: The target field (head bits [9:8]) is the lowest-numbered enabled region whose masked match value equals the masked address bits [31:24]. It is 3 when no region matches.
- R3: Head bit 13 is 1 for a write and bit 12 is 1 for a burst, as given on the request.
- R4: A burst read is reported on its first data beat when control bit 1 is 0, and on the beat with `mon_rsp_last` when it is 1. All other transactions are reported on the beat with `mon_rsp_last`.
- R5: In short format every record is exactly one beat with `trc_last` high, laid out {overflow[15], trigger[14], write[13], burst[12], initiator[11:10], target[9:8], latency[7:0]}.
- R6: In full format a record is three beats: the head beat, then address bits [23:8], then {8'h00, address bits [31:24]}; `trc_last` is high on the third only.
- R7: With the stream stalled, five records are held (four in the FIFO, one in the output stage) and further ones are dropped. The next stored record has head bit 15 set, and later records have it clear.
- R8: The initiator field carries control bits [9:8] when control bit 2 is set, and zero otherwise.
- R9: If `trig_in` was high at any edge since the last stored record, including the storing edge, the next stored record has head bit 14 set. Otherwise bit 14 is clear.
- R10: A request accepted while a transaction is outstanding produces no record and does not disturb the timed one.
- R11: While `trc_vld` is high and `trc_rdy` is low, `trc_vld`, `trc_data` and `trc_last` keep their values into the next cycle.
- R12: While `en` is low, no record is stored and no new record starts on the stream. A record already started is sent to its end, and stored records are kept for when `en` returns.
- R13: After reset `trc_vld` is low. With the stream idle, a record's first beat is presented in the second cycle after its reporting beat edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture enable |
| trig_in | input | 1 | On-chip trigger flag to be carried into records |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| mon_req_vld | input | 1 | Observed request valid |
| mon_req_rdy | input | 1 | Observed request ready |
| mon_req_wr | input | 1 | Observed request is a write |
| mon_req_burst | input | 1 | Observed request is a burst |
| mon_req_addr | input | 32 | Observed request address |
| mon_rsp_vld | input | 1 | Observed response beat valid |
| mon_rsp_rdy | input | 1 | Observed response beat ready |
| mon_rsp_last | input | 1 | Observed response beat is the last |
| trc_vld | output | 1 | Trace beat valid |
| trc_rdy | input | 1 | Trace beat accepted by the consumer |
| trc_data | output | 16 | Trace beat payload |
| trc_last | output | 1 | Final beat of a record |

## Verification
A record is stored at the edge of its reporting response beat, taken into the output stage one edge later, and presented from then on. The bench samples `trc_vld` one cycle after that beat, where it must still be low, and again a cycle later, where it must be high. Every other beat is compared in order, at the falling edge before the rising edge that accepts it, against a queue that the transaction driver fills from the configuration it wrote. Drops and holds are checked by the queue's length after a fixed idle window: a beat that should have been dropped or held shows up as an unexpected or out-of-order beat.

// File: rtl/trc_pkg.sv
`timescale 1ns/1ps
package trc_pkg;
  typedef enum logic [1:0] {TRK_IDLE, TRK_WAIT, TRK_DRAIN} trk_state_t;

  // control word bit positions
  localparam int CTL_FULL  = 0;
  localparam int CTL_LAST  = 1;
  localparam int CTL_MULTI = 2;
  localparam int CTL_IID   = 8;
endpackage

// File: rtl/trc_cfg_regs.sv
`timescale 1ns/1ps
module trc_cfg_regs #(
  parameter int NREG = 3,
  parameter int MW   = 8,
  parameter int IW   = 2,
  parameter int DW   = 32,
  parameter int CAW  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic [CAW-1:0]           cfg_addr,
  input  logic [DW-1:0]            cfg_wdata,
  output logic                     full_mode,
  output logic                     on_last,
  output logic                     multi,
  output logic [IW-1:0]            iid,
  output logic [NREG-1:0]          rg_en,
  output logic [NREG-1:0][MW-1:0]  rg_base,
  output logic [NREG-1:0][MW-1:0]  rg_mask
);
  import trc_pkg::*;

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_mode <= 1'b0;
      on_last   <= 1'b0;
      multi     <= 1'b0;
      iid       <= '0;
      rg_en     <= '0;
      rg_base   <= '0;
      rg_mask   <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr == '0) begin
        full_mode <= cfg_wdata[CTL_FULL];
        on_last   <= cfg_wdata[CTL_LAST];
        multi     <= cfg_wdata[CTL_MULTI];
        iid       <= cfg_wdata[CTL_IID +: IW];
      end
      for (int i = 0; i < NREG; i++) begin
        if (cfg_addr == CAW'(i + 1)) begin
          rg_base[i] <= cfg_wdata[MW-1:0];
          rg_mask[i] <= cfg_wdata[2*MW-1:MW];
          rg_en[i]   <= cfg_wdata[2*MW];
        end
      end
    end
  end
endmodule

// File: rtl/trc_region_dec.sv
`timescale 1ns/1ps
module trc_region_dec #(
  parameter int NREG = 3,
  parameter int MW   = 8,
  parameter int TW   = 2
) (
  input  logic [MW-1:0]            key,
  input  logic [NREG-1:0]          rg_en,
  input  logic [NREG-1:0][MW-1:0]  rg_base,
  input  logic [NREG-1:0][MW-1:0]  rg_mask,
  output logic [TW-1:0]            tid
);
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign hit[g] = rg_en[g] && ((key & rg_mask[g]) == (rg_base[g] & rg_mask[g]));
  end

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    tid = TW'(NREG);
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) tid = TW'(i);
    end
  end
endmodule

// File: rtl/trc_tracker.sv
`timescale 1ns/1ps
module trc_tracker #(
  parameter int LW  = 8,
  parameter int IW  = 2,
  parameter int TW  = 2,
  parameter int UAW = 24,
  parameter int BW  = 16,
  parameter int RW  = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           trig_in,
  input  logic           req_fire,
  input  logic           req_wr,
  input  logic           req_burst,
  input  logic [UAW-1:0] req_hi,
  input  logic [TW-1:0]  req_tid,
  input  logic           rsp_fire,
  input  logic           rsp_last,
  input  logic           on_last,
  input  logic           multi,
  input  logic [IW-1:0]  iid,
  input  logic           fifo_full,
  output logic           rec_want,
  output logic           rec_push,
  output logic [RW-1:0]  rec_data
);
  import trc_pkg::*;

  trk_state_t     st;
  logic [LW-1:0]  lat;
  logic           wr_q, burst_q, trg_q, ovf_q;
  logic [UAW-1:0] hi_q;
  logic [TW-1:0]  tid_q;
  logic           report;
  logic [BW-1:0]  head;

  assign report   = (st == TRK_WAIT) && rsp_fire &&
                    ((burst_q && !wr_q && !on_last) || rsp_last);
  assign rec_want = report && en;
  assign rec_push = rec_want && !fifo_full;

  assign head     = {ovf_q, trg_q | trig_in, wr_q, burst_q,
                     multi ? iid : IW'(0), tid_q, lat};
  assign rec_data = {hi_q, head};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= TRK_IDLE;
      lat     <= '0;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
      hi_q    <= '0;
      tid_q   <= '0;
    end else if (!en) begin
      st <= TRK_IDLE;
    end else begin
      case (st)
        TRK_IDLE: if (req_fire) begin
          st      <= TRK_WAIT;
          lat     <= LW'(1);
          wr_q    <= req_wr;
          burst_q <= req_burst;
          hi_q    <= req_hi;
          tid_q   <= req_tid;
        end
        TRK_WAIT: if (report) begin
          st <= rsp_last ? TRK_IDLE : TRK_DRAIN;
        end else begin
          lat <= (lat == '1) ? lat : lat + 1'b1;
        end
        TRK_DRAIN: if (rsp_fire && rsp_last) st <= TRK_IDLE;
        default: st <= TRK_IDLE;
      endcase
    end
  end

  // sticky flags, consumed by the next stored record
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trg_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (rec_push)     trg_q <= 1'b0;
      else if (trig_in) trg_q <= 1'b1;
      if (rec_push)      ovf_q <= 1'b0;
      else if (rec_want) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/trc_fifo.sv
`timescale 1ns/1ps
module trc_fifo #(
  parameter int W     = 40,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/trc_serializer.sv
`timescale 1ns/1ps
module trc_serializer #(
  parameter int BW  = 16,
  parameter int UAW = 24,
  parameter int RW  = 40,
  parameter int NXB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          full_mode,
  input  logic          fifo_empty,
  input  logic [RW-1:0] fifo_rdata,
  output logic          fifo_pop,
  output logic          trc_vld,
  input  logic          trc_rdy,
  output logic [BW-1:0] trc_data,
  output logic          trc_last
);
  localparam int IXW = $clog2(NXB + 1);

  logic              busy, full_q, fire, done;
  logic [IXW-1:0]    idx, last_idx;
  logic [RW-1:0]     rec_q;
  logic [NXB*BW-1:0] padded;

  assign last_idx = full_q ? IXW'(NXB) : '0;
  assign trc_vld  = busy;
  assign trc_last = busy && (idx == last_idx);
  assign fire     = busy && trc_rdy;
  assign done     = fire && trc_last;
  assign fifo_pop = (!busy || done) && !fifo_empty && en;

  always_comb begin
    padded = '0;
    padded[UAW-1:0] = rec_q[RW-1:BW];
  end

  always_comb begin
    trc_data = rec_q[BW-1:0];
    for (int k = 0; k < NXB; k++) begin
      if (idx == IXW'(k + 1)) trc_data = padded[k*BW +: BW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      full_q <= 1'b0;
      idx    <= '0;
      rec_q  <= '0;
    end else if (fifo_pop) begin
      busy   <= 1'b1;
      full_q <= full_mode;
      idx    <= '0;
      rec_q  <= fifo_rdata;
    end else if (done) begin
      busy <= 1'b0;
    end else if (fire) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/trc_capture_agent.sv
`timescale 1ns/1ps
module trc_capture_agent #(
  parameter int AW    = 32,
  parameter int UAW   = 24,
  parameter int MW    = 8,
  parameter int NREG  = 3,
  parameter int LW    = 8,
  parameter int IW    = 2,
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  localparam int TW   = $clog2(NREG + 1),
  localparam int CAW  = $clog2(NREG + 1),
  localparam int BW   = 4 + IW + TW + LW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           trig_in,
  input  logic           cfg_wr,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic           mon_req_vld,
  input  logic           mon_req_rdy,
  input  logic           mon_req_wr,
  input  logic           mon_req_burst,
  input  logic [AW-1:0]  mon_req_addr,
  input  logic           mon_rsp_vld,
  input  logic           mon_rsp_rdy,
  input  logic           mon_rsp_last,
  output logic           trc_vld,
  input  logic           trc_rdy,
  output logic [BW-1:0]  trc_data,
  output logic           trc_last
);
  localparam int RW  = UAW + BW;
  localparam int NXB = (UAW + BW - 1) / BW;

  logic                    full_mode, on_last, multi;
  logic [IW-1:0]           iid;
  logic [NREG-1:0]         rg_en;
  logic [NREG-1:0][MW-1:0] rg_base, rg_mask;
  logic [TW-1:0]           req_tid;
  logic                    rec_want, rec_push, fifo_full, fifo_empty, fifo_pop;
  logic [RW-1:0]           rec_data, fifo_rdata;
  logic                    unused_addr_lo;

  assign unused_addr_lo = ^mon_req_addr[AW-UAW-1:0];

  trc_cfg_regs #(.NREG(NREG), .MW(MW), .IW(IW), .DW(DW), .CAW(CAW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .full_mode(full_mode), .on_last(on_last),
    .multi(multi), .iid(iid), .rg_en(rg_en), .rg_base(rg_base), .rg_mask(rg_mask)
  );

  trc_region_dec #(.NREG(NREG), .MW(MW), .TW(TW)) u_dec (
    .key(mon_req_addr[AW-1 -: MW]), .rg_en(rg_en), .rg_base(rg_base),
    .rg_mask(rg_mask), .tid(req_tid)
  );

  trc_tracker #(.LW(LW), .IW(IW), .TW(TW), .UAW(UAW), .BW(BW), .RW(RW)) u_trk (
    .clk(clk), .rst_n(rst_n), .en(en), .trig_in(trig_in),
    .req_fire(mon_req_vld && mon_req_rdy), .req_wr(mon_req_wr),
    .req_burst(mon_req_burst), .req_hi(mon_req_addr[AW-1 -: UAW]),
    .req_tid(req_tid), .rsp_fire(mon_rsp_vld && mon_rsp_rdy),
    .rsp_last(mon_rsp_last), .on_last(on_last), .multi(multi), .iid(iid),
    .fifo_full(fifo_full), .rec_want(rec_want), .rec_push(rec_push),
    .rec_data(rec_data)
  );

  trc_fifo #(.W(RW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rec_push), .wdata(rec_data),
    .pop(fifo_pop), .rdata(fifo_rdata), .full(fifo_full), .empty(fifo_empty)
  );

  trc_serializer #(.BW(BW), .UAW(UAW), .RW(RW), .NXB(NXB)) u_ser (
    .clk(clk), .rst_n(rst_n), .en(en), .full_mode(full_mode),
    .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop),
    .trc_vld(trc_vld), .trc_rdy(trc_rdy), .trc_data(trc_data), .trc_last(trc_last)
  );
endmodule

// File: rtl/trc_agent_chk.sv
`timescale 1ns/1ps
module trc_agent_chk #(
  parameter int BW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          trc_vld,
  input logic          trc_rdy,
  input logic [BW-1:0] trc_data,
  input logic          trc_last,
  input logic          fifo_full,
  input logic          rec_want,
  input logic          fifo_push,
  input logic          push_ovf
);
  // a drop has happened since the last stored record
  logic lost;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     lost <= 1'b0;
    else if (fifo_push)             lost <= 1'b0;
    else if (rec_want && fifo_full) lost <= 1'b1;
  end

  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_vld && !trc_rdy) |=> (trc_vld && $stable(trc_data) && $stable(trc_last)));

  a_r12_no_start_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !trc_vld) |=> !trc_vld);

  a_r12_no_store_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !fifo_push);

  a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_push);

  a_r7_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> (push_ovf == lost));
endmodule

bind trc_capture_agent trc_agent_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .trc_vld(trc_vld), .trc_rdy(trc_rdy),
  .trc_data(trc_data), .trc_last(trc_last), .fifo_full(fifo_full),
  .rec_want(rec_want), .fifo_push(rec_push), .push_ovf(rec_data[BW-1])
);

// File: tb/sim_trc_capture_agent.sv
`timescale 1ns/1ps
module sim_trc_capture_agent;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic        trig_in = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        mon_req_vld = 1'b0, mon_req_rdy = 1'b0, mon_req_wr = 1'b0;
  logic        mon_req_burst = 1'b0;
  logic [31:0] mon_req_addr = '0;
  logic        mon_rsp_vld = 1'b0, mon_rsp_rdy = 1'b1, mon_rsp_last = 1'b0;
  logic        trc_vld, trc_last;
  logic        trc_rdy = 1'b1;
  logic [15:0] trc_data;

  always #4 clk = ~clk;

  trc_capture_agent u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .trig_in(trig_in), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .mon_req_vld(mon_req_vld),
    .mon_req_rdy(mon_req_rdy), .mon_req_wr(mon_req_wr),
    .mon_req_burst(mon_req_burst), .mon_req_addr(mon_req_addr),
    .mon_rsp_vld(mon_rsp_vld), .mon_rsp_rdy(mon_rsp_rdy),
    .mon_rsp_last(mon_rsp_last), .trc_vld(trc_vld), .trc_rdy(trc_rdy),
    .trc_data(trc_data), .trc_last(trc_last)
  );

  int checks = 0, failures = 0;
  logic [16:0] exp_q[$];
  string       tag_q[$];

  // bench model of the configuration it wrote
  bit       m_full = 0, m_last = 0, m_multi = 0;
  bit [1:0] m_iid = 0;
  bit [2:0] m_ren = 0;
  bit [7:0] m_rbase [3];
  bit [7:0] m_rmask [3];

  // output-ready shaping
  bit stall_all = 0, wobble = 0;
  int cyc = 0;
  always @(posedge clk) begin
    #1;
    cyc++;
    trc_rdy = stall_all ? 1'b0 : (wobble ? ((cyc % 3) != 0) : 1'b1);
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // scoreboard monitor: compare each beat at the falling edge before it is taken
  always @(negedge clk) begin
    if (rst_n && trc_vld && trc_rdy) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12/R7 unexpected beat", {15'd0, trc_last, trc_data}, 32'h0);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({trc_last, trc_data} == e, t, {15'd0, trc_last, trc_data}, {15'd0, e});
      end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick;
    cfg_wr = 1'b0;
    if (a == 0) begin
      m_full = d[0]; m_last = d[1]; m_multi = d[2]; m_iid = d[9:8];
    end else begin
      m_rbase[a-1] = d[7:0]; m_rmask[a-1] = d[15:8]; m_ren[a-1] = d[16];
    end
  endtask

  function automatic bit [1:0] exp_tid(input logic [31:0] addr);
    for (int i = 0; i < 3; i++)
      if (m_ren[i] && ((addr[31:24] & m_rmask[i]) == (m_rbase[i] & m_rmask[i])))
        return 2'(i);
    return 2'd3;
  endfunction

  task automatic exp_record(input bit ovf, input bit trg, input bit wr, input bit burst,
                            input logic [31:0] addr, input int lat, input string tag);
    logic [15:0] head;
    head = {ovf, trg, wr, burst, m_multi ? m_iid : 2'b00, exp_tid(addr), 8'(lat)};
    exp_q.push_back({~m_full, head});       tag_q.push_back(tag);
    if (m_full) begin
      exp_q.push_back({1'b0, addr[23:8]});    tag_q.push_back({tag, " R6 beat1"});
      exp_q.push_back({1'b1, 8'h00, addr[31:24]}); tag_q.push_back({tag, " R6 beat2"});
    end
  endtask

  task automatic txn(input bit wr, input bit burst, input logic [31:0] addr,
                     input int nb, input int dly, input bit ovf, input bit trg,
                     input bit keep, input bit chk_time, input string tag);
    int lat;
    lat = (!wr && burst && !m_last) ? dly + 1 : dly + nb;
    if (lat > 255) lat = 255;
    if (keep) exp_record(ovf, trg, wr, burst, addr, lat, tag);
    mon_req_vld = 1; mon_req_rdy = 1; mon_req_wr = wr; mon_req_burst = burst;
    mon_req_addr = addr;
    tick;
    mon_req_vld = 0;
    repeat (dly) tick;
    for (int b = 0; b < nb; b++) begin
      mon_rsp_vld = 1; mon_rsp_last = (b == nb - 1);
      tick;
    end
    mon_rsp_vld = 0; mon_rsp_last = 0;
    if (chk_time) begin
      check(trc_vld == 1'b0, "R13 beat not yet due", {31'd0, trc_vld}, 32'd0);
      tick;
      check(trc_vld == 1'b1, "R13 beat due", {31'd0, trc_vld}, 32'd1);
    end
    tick; tick;
  endtask

  task automatic drain;
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin tick; n++; end
    repeat (3) tick;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) tick;
    check(trc_vld == 1'b0, "R13 reset valid", {31'd0, trc_vld}, 32'd0);
    rst_n = 1'b1;
    tick;
    check(trc_vld == 1'b0, "R13 idle after reset", {31'd0, trc_vld}, 32'd0);

    // regions: 0 -> 0x1X, 1 -> exactly 0x20, 2 -> top bit set
    cfg_write(2'd1, 32'h0001_F010);
    cfg_write(2'd2, 32'h0001_FF20);
    cfg_write(2'd3, 32'h0001_8080);
    cfg_write(2'd0, 32'h0000_0200);   // short, first-beat, single initiator, iid 2 ignored

    txn(0, 0, 32'h1234_5678, 1, 3, 0, 0, 1, 1, "R1 R2 R3 R5 R8 read single");
    txn(1, 0, 32'h2000_0000, 1, 0, 0, 0, 1, 0, "R1 R2 R3 write single");
    txn(0, 1, 32'h9000_0000, 4, 2, 0, 0, 1, 0, "R4 burst read first beat");
    txn(1, 1, 32'h4000_0000, 1, 5, 0, 0, 1, 0, "R2 R3 no region write burst");
    drain();

    cfg_write(2'd0, 32'h0000_0206);   // last-beat reporting, multi on
    txn(0, 1, 32'h2100_0000, 4, 1, 0, 0, 1, 0, "R4 R8 burst read last beat");
    txn(0, 0, 32'h1F00_0000, 1, 253, 0, 0, 1, 0, "R1 latency 254");
    txn(0, 0, 32'h1F00_0000, 1, 254, 0, 0, 1, 0, "R1 latency 255");
    txn(0, 0, 32'h1F00_0000, 1, 300, 0, 0, 1, 0, "R1 latency saturates");
    drain();

    // priority: region 2 now matches everything, region 0 must still win
    cfg_write(2'd3, 32'h0001_0000);
    txn(1, 0, 32'h1A00_0000, 1, 0, 0, 0, 1, 0, "R2 lowest region wins");
    txn(1, 0, 32'h7700_0000, 1, 0, 0, 0, 1, 0, "R2 catch-all region");
    cfg_write(2'd3, 32'h0000_8080);   // region 2 disabled

    // trigger pulse between records
    trig_in = 1; tick; trig_in = 0; tick;
    txn(0, 0, 32'h8000_0000, 1, 1, 0, 1, 1, 0, "R9 trigger carried");
    txn(0, 0, 32'h8000_0000, 1, 1, 0, 0, 1, 0, "R9 trigger cleared");
    drain();

    // second request while one is outstanding
    exp_record(0, 0, 0, 0, 32'h1000_0000, 4, "R10 timed request only");
    mon_req_vld = 1; mon_req_rdy = 1; mon_req_wr = 0; mon_req_burst = 0;
    mon_req_addr = 32'h1000_0000;
    tick;
    mon_req_vld = 0; tick;
    mon_req_vld = 1; mon_req_wr = 1; mon_req_addr = 32'h2000_0000; tick;
    mon_req_vld = 0; tick;
    mon_rsp_vld = 1; mon_rsp_last = 1; tick;
    mon_rsp_vld = 0; mon_rsp_last = 0;
    repeat (10) tick;
    drain();

    // full format, with a wobbling consumer
    cfg_write(2'd0, 32'h0000_0201);
    wobble = 1;
    txn(0, 0, 32'hABCD_EF12, 1, 2, 0, 0, 1, 0, "R6 full read");
    txn(1, 1, 32'h1234_5600, 1, 0, 0, 0, 1, 0, "R6 R11 full write burst");
    txn(0, 0, 32'h9876_5400, 1, 4, 0, 0, 1, 0, "R6 R11 full read");
    drain();
    wobble = 0;

    // overflow: stalled stream keeps five records
    cfg_write(2'd0, 32'h0000_0000);
    stall_all = 1; tick; tick;
    for (int i = 0; i < 5; i++)
      txn(0, 0, 32'h1000_0000 + 32'(i), 1, i, 0, 0, 1, 0, "R7 held record");
    txn(0, 0, 32'h2000_0000, 1, 0, 0, 0, 0, 0, "R7 dropped");
    stall_all = 0;
    txn(1, 0, 32'h2000_0000, 1, 1, 1, 0, 1, 0, "R7 overflow flag set");
    txn(1, 0, 32'h2000_0000, 1, 1, 0, 0, 1, 0, "R7 overflow flag cleared");
    drain();

    // enable: in-flight record finishes, stored record waits
    cfg_write(2'd0, 32'h0000_0001);
    stall_all = 1; tick; tick;
    txn(0, 0, 32'hA100_0000, 1, 0, 0, 0, 1, 0, "R12 in-flight record");
    txn(0, 0, 32'hA200_0000, 1, 0, 0, 0, 1, 0, "R12 stored record");
    en = 0; tick;
    stall_all = 0;
    txn(0, 0, 32'hA300_0000, 1, 0, 0, 0, 0, 0, "R12 no capture");
    repeat (20) tick;
    check(exp_q.size() == 3, "R12 held while disabled", 32'(exp_q.size()), 32'd3);
    en = 1;
    drain();

    check(exp_q.size() == 0, "R12 R7 all expected beats seen", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule